// File: doc/BRIEF.md
# Serial Converter Sample Reader

This block is the host side of a three-wire link to a 16-bit sampling converter that returns each result serially. The three wires are an active-low select, a data clock and a data return line. A frame begins on a pulse of `start_i`, or on a tick of an internal sample-rate timer while `auto_i` is high. The block then lowers the select line and produces the data clock by dividing the system clock.

The converter uses the first clocks of every frame to convert, so the block throws those clocks away. It also discards the single zero bit that the converter sends ahead of the data. The next 16 bits are shifted in, most significant bit first. Every bit is taken at the falling edge of the data clock, from the value that was on the line just before that edge. After a programmable number of clocks the select line goes high again, and the straight-binary result appears on `sample_o` together with a one-cycle `valid_o` strobe.

While select is high the converter acquires and rests, so the block keeps select high for a minimum number of system clocks before the next frame can begin. The divider, the frame length, the number of conversion clocks, the rest time and the timer period are all parameters counted in system clocks.

Top module: `adc_frame_reader`

## Requirements
- R1: During or after a synchronous reset, `cs_n_o` is 1, `sclk_o` is 0, `busy_o` is 0 and `valid_o` is 0. A frame that is in progress is abandoned.
- R2: A `start_i` pulse sampled while `busy_o` is low sets `busy_o` to 1 in the next cycle. If the block is idle, the same pulse also lowers `cs_n_o` in the next cycle.
- R3: While `cs_n_o` is high, `sclk_o` is 0. After `cs_n_o` falls, `sclk_o` stays low for HALF_DIV system cycles. After that, every high phase and every low phase lasts exactly HALF_DIV cycles.
- R4: A frame has exactly FRAME_CLKS rising edges of `sclk_o`. `cs_n_o` rises in the same cycle as the last falling edge.
- R5: Counting data clocks from 1, clocks 1 to CONV_CLKS and clock CONV_CLKS+1 (the zero bit) are discarded. The next 16 clocks give `sample_o` bits 15 down to 0, in that order. Any clock after those 16 has no effect on `sample_o`.
- R6: The bit for clock k is the value of `sdo_i` on the system cycle just before the falling edge of clock k. A change in `sdo_i` that comes after that falling edge is taken for clock k+1.
- R7: `valid_o` is high for exactly one cycle per frame, in the first cycle with `cs_n_o` high, and `sample_o` then holds the result. `busy_o` is low in that cycle, and it was high in the cycle before.
- R8: A `start_i` pulse or timer tick that arrives while `busy_o` is high starts no extra frame.
- R9: A `start_i` pulse that arrives while the select line is resting sets `busy_o`. The requested frame starts as soon as the rest time is over.
- R10: While `auto_i` is high, the timer requests a frame every RATE_CYC system cycles. When a frame fits within that period, consecutive falls of `cs_n_o` are exactly RATE_CYC cycles apart.
- R11: Between two frames, `cs_n_o` stays high for exactly CS_REST_CYC cycles when a request is waiting, and for at least that long otherwise.
- R12: With the configured SYS_HZ, no phase of `sclk_o` is shorter than the length that corresponds to a 2.9 MHz clock. The select line never rests for less than 400 ns.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Single-cycle frame request |
| auto_i | input | 1 | Enables the sample-rate timer |
| sdo_i | input | 1 | Serial data from the converter |
| cs_n_o | output | 1 | Active-low select to the converter |
| sclk_o | output | 1 | Divided data clock to the converter |
| busy_o | output | 1 | High from an accepted request until its result strobe |
| valid_o | output | 1 | One-cycle strobe for a new result |
| sample_o | output | DATA_W | Last captured straight-binary result |

## Verification
The bench builds the block with FRAME_CLKS set to 24 instead of 22, which places two extra clocks after the LSB. During those clocks the converter model drives ones, so any capture that runs past the window corrupts the result. The model also drives ones during the conversion clocks, which exposes a window that starts too early. The bench keeps HALF_DIV at 44 and CS_REST_CYC at 100 at 250 MHz, right at the speed and rest limits, so the phase-length and rest-length checks sit on their boundaries. With RATE_CYC at 2500, a complete frame plus its rest fits within one timer period. This makes the timer interval visible as the exact spacing between falls of the select line.

// File: rtl/afr_pkg.sv
package afr_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_LEAD,
        ST_SHIFT,
        ST_REST
    } afr_state_e;

endpackage

// File: rtl/afr_tick.sv
// Periodic tick generator: fires once every PERIOD enabled cycles.
module afr_tick #(
    parameter int PERIOD = 44
) (
    input  logic clk,
    input  logic rst,
    input  logic en,
    output logic tick
);
    localparam int CW = (PERIOD > 1) ? $clog2(PERIOD) : 1;
    localparam logic [CW-1:0] LAST = CW'(PERIOD - 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (!en || cnt_q == LAST) begin
            cnt_d = '0;
        end else begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign tick = en && (cnt_q == LAST);

endmodule

// File: rtl/afr_shift_in.sv
// MSB-first serial-to-parallel register.
module afr_shift_in #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         shift_en,
    input  logic         din,
    output logic [W-1:0] q
);
    logic [W-1:0] sh_d, sh_q;

    always_comb begin
        sh_d = sh_q;
        if (shift_en) begin
            sh_d = {sh_q[W-2:0], din};
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sh_q <= '0;
        end else begin
            sh_q <= sh_d;
        end
    end

    assign q = sh_q;

endmodule

// File: rtl/adc_frame_reader.sv
module adc_frame_reader
    import afr_pkg::*;
#(
    parameter int SYS_HZ      = 250_000_000,
    parameter int DATA_W      = 16,
    parameter int CONV_CLKS   = 5,
    parameter int FRAME_CLKS  = 22,
    parameter int HALF_DIV    = 44,
    parameter int CS_REST_CYC = 100,
    parameter int RATE_CYC    = 2500
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start_i,
    input  logic              auto_i,
    input  logic              sdo_i,
    output logic              cs_n_o,
    output logic              sclk_o,
    output logic              busy_o,
    output logic              valid_o,
    output logic [DATA_W-1:0] sample_o
);
    localparam int EW        = $clog2(FRAME_CLKS + 1);
    localparam int RW        = (CS_REST_CYC > 1) ? $clog2(CS_REST_CYC) : 1;
    localparam int FIRST_BIT = CONV_CLKS + 2;
    localparam int LAST_BIT  = CONV_CLKS + 1 + DATA_W;

    typedef struct packed {
        afr_state_e    state;
        logic          cs_n;
        logic          sclk;
        logic [EW-1:0] rises;
        logic [RW-1:0] rest_cnt;
        logic          pending;
        logic          valid;
    } regs_t;

    regs_t r_d, r_q;
    logic  div_en, half_tick, rate_tick, req, shift_en;

    assign div_en = (r_q.state == ST_LEAD) || (r_q.state == ST_SHIFT);

    afr_tick #(.PERIOD(HALF_DIV)) u_half (
        .clk  (clk),
        .rst  (rst),
        .en   (div_en),
        .tick (half_tick)
    );

    generate
        if (RATE_CYC > 0) begin : g_rate
            afr_tick #(.PERIOD(RATE_CYC)) u_rate (
                .clk  (clk),
                .rst  (rst),
                .en   (auto_i),
                .tick (rate_tick)
            );
        end else begin : g_norate
            assign rate_tick = 1'b0;
        end
    endgenerate

    afr_shift_in #(.W(DATA_W)) u_shift (
        .clk      (clk),
        .rst      (rst),
        .shift_en (shift_en),
        .din      (sdo_i),
        .q        (sample_o)
    );

    assign req = start_i || rate_tick;

    always_comb begin
        r_d      = r_q;
        r_d.valid = 1'b0;
        shift_en = 1'b0;
        case (r_q.state)
            ST_IDLE: begin
                if (req) begin
                    r_d.state = ST_LEAD;
                    r_d.cs_n  = 1'b0;
                    r_d.rises = '0;
                end
            end
            ST_LEAD: begin
                // select has been low for one half period: first rising edge
                if (half_tick) begin
                    r_d.sclk  = 1'b1;
                    r_d.rises = EW'(1);
                    r_d.state = ST_SHIFT;
                end
            end
            ST_SHIFT: begin
                if (half_tick) begin
                    if (r_q.sclk) begin
                        // falling edge: take the bit valid during this clock
                        r_d.sclk = 1'b0;
                        shift_en = (int'(r_q.rises) >= FIRST_BIT) &&
                                   (int'(r_q.rises) <= LAST_BIT);
                        if (r_q.rises == EW'(FRAME_CLKS)) begin
                            r_d.state    = ST_REST;
                            r_d.cs_n     = 1'b1;
                            r_d.valid    = 1'b1;
                            r_d.rest_cnt = '0;
                            r_d.pending  = 1'b0;
                        end
                    end else begin
                        r_d.sclk  = 1'b1;
                        r_d.rises = r_q.rises + 1'b1;
                    end
                end
            end
            ST_REST: begin
                if (req) begin
                    r_d.pending = 1'b1;
                end
                if (r_q.rest_cnt == RW'(CS_REST_CYC - 1)) begin
                    if (r_q.pending || req) begin
                        r_d.state   = ST_LEAD;
                        r_d.cs_n    = 1'b0;
                        r_d.rises   = '0;
                        r_d.pending = 1'b0;
                    end else begin
                        r_d.state = ST_IDLE;
                    end
                end else begin
                    r_d.rest_cnt = r_q.rest_cnt + 1'b1;
                end
            end
            default: r_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            r_q <= '{state: ST_IDLE, cs_n: 1'b1, sclk: 1'b0, rises: '0,
                     rest_cnt: '0, pending: 1'b0, valid: 1'b0};
        end else begin
            r_q <= r_d;
        end
    end

    assign cs_n_o  = r_q.cs_n;
    assign sclk_o  = r_q.sclk;
    assign valid_o = r_q.valid;
    assign busy_o  = div_en || r_q.pending;

endmodule

// File: rtl/afr_checker.sv
module afr_checker #(
    parameter int SYS_HZ      = 250_000_000,
    parameter int FRAME_CLKS  = 22
) (
    input logic clk,
    input logic rst,
    input logic start,
    input logic cs_n,
    input logic sclk,
    input logic busy,
    input logic valid
);
    localparam longint HALF_MIN = (longint'(SYS_HZ) + 64'd5_799_999) / 64'd5_800_000;
    localparam longint REST_MIN = (longint'(SYS_HZ) * 64'd400 + 64'd999_999_999) / 64'd1_000_000_000;

    logic        last_sclk;
    logic [15:0] ph_cnt, hi_cnt;
    logic [7:0]  rise_cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            last_sclk <= 1'b0;
            ph_cnt    <= 16'(HALF_MIN);
            hi_cnt    <= 16'(REST_MIN);
            rise_cnt  <= '0;
        end else begin
            last_sclk <= sclk;
            if (sclk != last_sclk)   ph_cnt <= 16'd1;
            else if (ph_cnt != 16'hFFFF) ph_cnt <= ph_cnt + 16'd1;
            if (!cs_n)               hi_cnt <= '0;
            else if (hi_cnt != 16'hFFFF) hi_cnt <= hi_cnt + 16'd1;
            if (cs_n)                rise_cnt <= '0;
            else if (sclk && !last_sclk) rise_cnt <= rise_cnt + 8'd1;
        end
    end

    AST_CLK_LOW_IDLE: assert property (@(posedge clk) disable iff (rst)
        cs_n |-> !sclk);                                            // R3
    AST_SELECT_SETUP: assert property (@(posedge clk) disable iff (rst)
        $rose(sclk) |-> $past(!cs_n));                              // R3
    AST_EDGE_COUNT: assert property (@(posedge clk) disable iff (rst)
        $rose(cs_n) |-> rise_cnt == 8'(FRAME_CLKS));                // R4
    AST_START_BUSY: assert property (@(posedge clk) disable iff (rst)
        (start && !busy) |=> busy);                                 // R2
    AST_VALID_ONE: assert property (@(posedge clk) disable iff (rst)
        valid |=> !valid);                                          // R7
    AST_VALID_AT_RISE: assert property (@(posedge clk) disable iff (rst)
        valid |-> $rose(cs_n));                                     // R7
    AST_BUSY_DROP: assert property (@(posedge clk) disable iff (rst)
        valid |-> (!busy && $past(busy)));                          // R7
    AST_REST_MIN: assert property (@(posedge clk) disable iff (rst)
        $fell(cs_n) |-> hi_cnt >= 16'(REST_MIN));                   // R11
    AST_PHASE_MIN: assert property (@(posedge clk) disable iff (rst)
        (sclk != last_sclk) |-> ph_cnt >= 16'(HALF_MIN));           // R12

endmodule

bind adc_frame_reader afr_checker #(
    .SYS_HZ     (SYS_HZ),
    .FRAME_CLKS (FRAME_CLKS)
) u_afr_chk (
    .clk   (clk),
    .rst   (rst),
    .start (start_i),
    .cs_n  (cs_n_o),
    .sclk  (sclk_o),
    .busy  (busy_o),
    .valid (valid_o)
);

// File: tb/test_adc_frame_reader.sv
`timescale 1ns/1ps
module test_adc_frame_reader;
    localparam int CONV  = 5;
    localparam int FRAME = 24;
    localparam int HALF  = 44;
    localparam int REST  = 100;
    localparam int RATE  = 2500;
    localparam int NVEC  = 6;
    localparam logic [15:0] VEC [NVEC] = '{16'h0000, 16'hFFFF, 16'hA5C3,
                                           16'h8001, 16'h7FFE, 16'h1234};

    logic clk = 1'b0, rst = 1'b1, start = 1'b0, auto_en = 1'b0, sdo = 1'b1;
    logic cs_n, sclk, busy, valid;
    logic [15:0] sample;
    logic [15:0] cur = 16'h0;
    int total = 0, bad = 0, cyc = 0;
    int tot_rises = 0, base_rises = 0, falls = 0, fall_t = 0, prev_fall_t = 0;
    int bad_phase = 0, run = 0;
    logic prev_sclk = 1'b0, prev_cs = 1'b1;

    always #2 clk = ~clk;

    adc_frame_reader #(.SYS_HZ(250_000_000), .DATA_W(16), .CONV_CLKS(CONV),
        .FRAME_CLKS(FRAME), .HALF_DIV(HALF), .CS_REST_CYC(REST),
        .RATE_CYC(RATE)) i_adc_frame_reader (
        .clk(clk), .rst(rst), .start_i(start), .auto_i(auto_en), .sdo_i(sdo),
        .cs_n_o(cs_n), .sclk_o(sclk), .busy_o(busy), .valid_o(valid),
        .sample_o(sample));

    // converter model: bit for data clock k
    function automatic logic bitf(input int k);
        if (k <= CONV) return 1'b1;
        if (k == CONV + 1) return 1'b0;
        if (k <= CONV + 17) return cur[CONV + 17 - k];
        return 1'b1;
    endfunction

    initial forever begin
        @(negedge cs_n);
        sdo = bitf(1);
        for (int k = 1; k < 64; k++) begin
            @(negedge sclk or posedge cs_n);
            if (cs_n) break;
            #1 sdo = bitf(k + 1);
        end
        sdo = 1'b1;
    end

    always @(posedge clk) cyc <= cyc + 1;
    always @(posedge sclk) tot_rises++;
    always @(negedge cs_n) base_rises = tot_rises;

    always @(negedge clk) begin
        if (prev_cs && !cs_n) begin
            falls++; prev_fall_t = fall_t; fall_t = cyc; run = 1;
        end else if (!cs_n) begin
            if (sclk != prev_sclk) begin
                if (run != HALF) bad_phase++;
                run = 1;
            end else run++;
        end
        prev_cs = cs_n; prev_sclk = sclk;
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic wait_valid(output bit got);
        got = 1'b0;
        for (int i = 0; i < 6000; i++) begin
            @(negedge clk);
            if (valid) begin got = 1'b1; break; end
        end
    endtask

    task automatic pulse_start;
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic finish_frame(input logic [15:0] w, input int ph0);
        bit got;
        wait_valid(got);
        chk(got, "R7 valid seen", int'(got), 1);
        chk(sample == w, "R5 R6 sample", int'(sample), int'(w));
        chk(cs_n == 1'b1, "R4 cs high at strobe", int'(cs_n), 1);
        chk(busy == 1'b0, "R7 busy low at strobe", int'(busy), 0);
        chk(tot_rises - base_rises == FRAME, "R4 rising edges",
            tot_rises - base_rises, FRAME);
        chk(bad_phase == ph0, "R3 phase length", bad_phase - ph0, 0);
        @(negedge clk);
        chk(valid == 1'b0, "R7 single strobe", int'(valid), 0);
    endtask

    task automatic run_frame(input logic [15:0] w);
        int ph0;
        cur = w; ph0 = bad_phase;
        pulse_start();
        chk(cs_n == 1'b0 && busy == 1'b1, "R2 select low and busy",
            int'({cs_n, busy}), 1);
        finish_frame(w, ph0);
        idle(REST + 20);
    endtask

    initial begin
        #600000;
        bad++; total++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        bit got;
        int cnt, f0, ph0;
        idle(5);
        chk(cs_n && !sclk && !busy && !valid, "R1 reset state",
            int'({cs_n, sclk, busy, valid}), 8);
        @(negedge clk) rst = 1'b0;
        idle(3);

        // table of words, one frame each
        for (int v = 0; v < NVEC; v++) run_frame(VEC[v]);

        // R8: second request during a frame is ignored
        cur = 16'hC3A5; ph0 = bad_phase;
        pulse_start();
        idle(500);
        pulse_start();
        finish_frame(16'hC3A5, ph0);
        f0 = falls;
        idle(REST + 300);
        chk(falls == f0 && cs_n, "R8 no extra frame", falls - f0, 0);

        // R9 / R11: request during rest is deferred
        cur = 16'h5A0F;
        pulse_start();
        wait_valid(got);
        chk(sample == 16'h5A0F, "R5 sample before deferral", int'(sample), 16'h5A0F);
        start = 1'b1; cnt = 1;
        @(negedge clk) start = 1'b0;
        chk(busy && cs_n, "R9 busy while resting", int'({busy, cs_n}), 3);
        cur = 16'h0F5A; ph0 = bad_phase;
        for (int i = 0; i < 400 && cs_n; i++) begin
            cnt++;
            @(negedge clk);
        end
        chk(cnt == REST, "R11 rest length", cnt, REST);
        finish_frame(16'h0F5A, ph0);
        idle(REST + 20);

        // R10: timer-driven frames
        cur = 16'h3C96; f0 = falls;
        auto_en = 1'b1;
        for (int i = 0; i < 8000 && falls < f0 + 2; i++) @(negedge clk);
        chk(falls == f0 + 2, "R10 timer frames", falls - f0, 2);
        chk(fall_t - prev_fall_t == RATE, "R10 timer interval",
            fall_t - prev_fall_t, RATE);
        auto_en = 1'b0;
        wait_valid(got);
        chk(sample == 16'h3C96, "R10 timer sample", int'(sample), 16'h3C96);
        idle(REST + 20);

        // R1: reset in the middle of a frame
        cur = 16'hFFFF;
        pulse_start();
        idle(300);
        @(negedge clk) rst = 1'b1;
        @(negedge clk);
        chk(cs_n && !sclk && !busy && !valid, "R1 reset mid frame",
            int'({cs_n, sclk, busy, valid}), 8);
        idle(2);
        @(negedge clk) rst = 1'b0;
        idle(REST);
        chk(cs_n == 1'b1, "R1 stays idle", int'(cs_n), 1);
        run_frame(16'h6B2D);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule